// File: doc/BRIEF.md
# Command-Driven Parallel NOR Flash Model

This block is a synthesizable model of a parallel NOR flash device with a command interface. It sits on a simple synchronous bus with these signals: a byte address, a write strobe with write data, and a read strobe that returns read data one cycle later. The storage is a parameterized byte array held in flops. Reset fills the array with a preload value. Writes to the device are not stored directly. They are decoded as commands, and some commands take more than one bus cycle: single-word program, sector erase with confirm, status clear and status read, identifier read, query-table read, lock and unlock, and a buffered multi-word write that carries a count and ends with a confirm.

The latched command sets what a read returns: array words, the status register, identifier words or query-table bytes. A read-only input blocks changes to the array. With it high, program and erase attempts set error bits in the status register and leave the array untouched. Program and erase finish in a single cycle, so the ready bit is set as soon as a command is accepted.

Top module: `nor_cmd_flash`

## Requirements
- R1: After reset the status register reads 0x00, the device is in array-read mode, and every array byte holds the preload value. The default preload is 0xFF.
- R2: A read strobe returns, on the next cycle, the word at the address with the low lane bits ignored. Byte lane 0 (bits 7:0) holds the lowest address. rd_data holds its value in every cycle with no read strobe.
- R3: Command 0x40 or 0x10 arms a program. The next write stores its data word at its address and sets status bit 7 (ready). After that, reads return status until a return-to-array command is written.
- R4: With ro_mode high, the data write of a program leaves the array unchanged and sets status bits 4 (program error) and 7.
- R5: Command 0x20 fills the whole sector that holds the address with 0xFF in the same cycle and sets bit 7. Reads then show status. A second write of 0xD0 completes the erase. With ro_mode high, no byte changes and bit 5 (erase error) is set.
- R6: Command 0x50 clears the whole status register and returns to array-read mode.
- R7: Command 0x70 selects status reads. Command 0x90 selects identifier reads: word index 0 returns {ID0,ID1}, index 1 returns {ID2,ID3}, and any other index returns 0. The word index is address bits 7:0 shifted right by log2 of the bus width in bytes. Neither command moves the write sequence forward.
- R8: Command 0x98 selects query reads. Index 0x10..0x12 returns "QRY" (0x51, 0x52, 0x59). Index 0x2A returns the buffer size exponent (8 for a 1-byte bus, 11 otherwise). Any index at or beyond 0x52 returns 0. Later writes keep query mode, except 0xFF, which returns to array read.
- R9: Command 0x60 followed by 0xD0 or 0x01 completes with bit 7 set, and reads then show status. Any other second value returns to array read.
- R10: Command 0xE8 sets bit 7. The next write is a count N. The N+1 writes after it store words at their own addresses. A following 0xD0 completes the sequence with status reads selected. Status shows ready throughout the sequence.
- R11: An unknown command, or a wrong second value in an erase or buffered-write sequence, returns to array-read mode and leaves the status register unchanged.
- R12: Commands 0x00, 0xF0 and 0xFF return to array-read mode from any idle state and leave the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address, shared by reads and writes |
| wr_en | input | 1 | Write strobe (command or data) |
| wr_data | input | 8*BUS_BYTES | Write value; the command is taken from the low byte |
| rd_en | input | 1 | Read strobe |
| ro_mode | input | 1 | Write protect: turns program and erase into error reports |
| rd_data | output | 8*BUS_BYTES | Read value, registered one cycle after rd_en |

## Verification
The bench targets the cases where the latched command and the write cycle separate. Reads after a program or an erase must return status, not array data. A design that clears the command too early would return stale array words there. A read-only program is checked twice: the error bit must be set, and the word in the array must not change. A model that wrote anyway would show the new data once the device is back in array-read mode. The buffered write sends a count of 3, then four words, then a confirm, and checks the word just past the buffer. An off-by-one on the count either leaves the last word as a command or overwrites its neighbour. Wrong confirm values and unknown commands must return to array mode without clearing status. A design that reused the clear path would lose the ready bit.

// File: rtl/nfl_pkg.sv
package nfl_pkg;

   typedef enum logic [1:0] {
      CYC_IDLE    = 2'd0,
      CYC_ARG     = 2'd1,
      CYC_DATA    = 2'd2,
      CYC_CONFIRM = 2'd3
   } cyc_e;

   typedef enum logic [1:0] {
      RSEL_ARRAY,
      RSEL_STATUS,
      RSEL_IDENT,
      RSEL_QUERY
   } rsel_e;

   localparam logic [7:0] OP_ARRAY    = 8'h00;
   localparam logic [7:0] OP_PROG_A   = 8'h10;
   localparam logic [7:0] OP_PROG_B   = 8'h40;
   localparam logic [7:0] OP_ERASE    = 8'h20;
   localparam logic [7:0] OP_CLR_ST   = 8'h50;
   localparam logic [7:0] OP_LOCK     = 8'h60;
   localparam logic [7:0] OP_RD_ST    = 8'h70;
   localparam logic [7:0] OP_RD_ID    = 8'h90;
   localparam logic [7:0] OP_QUERY    = 8'h98;
   localparam logic [7:0] OP_BUF_WR   = 8'hE8;
   localparam logic [7:0] OP_CONFIRM  = 8'hD0;
   localparam logic [7:0] OP_LOCK_ALT = 8'h01;
   localparam logic [7:0] OP_ALT_RST  = 8'hF0;
   localparam logic [7:0] OP_RESET    = 8'hFF;

   localparam int ST_READY    = 7;
   localparam int ST_ERASE_ER = 5;
   localparam int ST_PROG_ER  = 4;

   localparam logic [7:0] QRY_LEN = 8'h52;

endpackage

// File: rtl/nfl_seq.sv
module nfl_seq
   import nfl_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ro_mode,
   output logic              prog_en,
   output logic              erase_en,
   output logic [7:0]        status,
   output logic [7:0]        cmd,
   output cyc_e              cyc,
   output rsel_e             rsel
);

   logic [7:0]        op;
   logic [7:0]        st_q, st_d, cmd_q, cmd_d;
   cyc_e              cyc_q, cyc_d;
   logic [DATA_W-1:0] cnt_q, cnt_d;
   logic              to_array;

   assign op = wr_data[7:0];

   always_comb begin
      st_d     = st_q;
      cmd_d    = cmd_q;
      cyc_d    = cyc_q;
      cnt_d    = cnt_q;
      prog_en  = 1'b0;
      erase_en = 1'b0;
      to_array = 1'b0;
      if (wr_en) begin
         case (cyc_q)
            CYC_IDLE: begin
               case (op)
                  OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY: begin
                     cmd_d = op;
                     cyc_d = CYC_ARG;
                  end
                  OP_ERASE: begin
                     erase_en = !ro_mode;
                     if (ro_mode) st_d[ST_ERASE_ER] = 1'b1;
                     st_d[ST_READY] = 1'b1;
                     cmd_d = op;
                     cyc_d = CYC_ARG;
                  end
                  OP_BUF_WR: begin
                     st_d[ST_READY] = 1'b1;
                     cmd_d = op;
                     cyc_d = CYC_ARG;
                  end
                  OP_RD_ST, OP_RD_ID: cmd_d = op;
                  OP_CLR_ST: begin
                     st_d     = '0;
                     to_array = 1'b1;
                  end
                  default: to_array = 1'b1;
               endcase
            end
            CYC_ARG: begin
               case (cmd_q)
                  OP_PROG_A, OP_PROG_B: begin
                     prog_en = !ro_mode;
                     if (ro_mode) st_d[ST_PROG_ER] = 1'b1;
                     st_d[ST_READY] = 1'b1;
                     cyc_d = CYC_IDLE;
                  end
                  OP_ERASE: begin
                     if (op == OP_CONFIRM) begin
                        st_d[ST_READY] = 1'b1;
                        cyc_d = CYC_IDLE;
                     end else begin
                        to_array = 1'b1;
                     end
                  end
                  OP_LOCK: begin
                     if (op == OP_CONFIRM || op == OP_LOCK_ALT) begin
                        st_d[ST_READY] = 1'b1;
                        cyc_d = CYC_IDLE;
                     end else begin
                        to_array = 1'b1;
                     end
                  end
                  OP_BUF_WR: begin
                     cnt_d = wr_data;
                     cyc_d = CYC_DATA;
                  end
                  OP_QUERY: to_array = (op == OP_RESET);
                  default: to_array = 1'b1;
               endcase
            end
            CYC_DATA: begin
               if (cmd_q == OP_BUF_WR) begin
                  prog_en = !ro_mode;
                  if (ro_mode) st_d[ST_PROG_ER] = 1'b1;
                  st_d[ST_READY] = 1'b1;
                  if (cnt_q == '0) cyc_d = CYC_CONFIRM;
                  else             cnt_d = cnt_q - 1'b1;
               end else begin
                  to_array = 1'b1;
               end
            end
            default: begin
               if (cmd_q == OP_BUF_WR && op == OP_CONFIRM) begin
                  st_d[ST_READY] = 1'b1;
                  cyc_d = CYC_IDLE;
               end else begin
                  to_array = 1'b1;
               end
            end
         endcase
         if (to_array) begin
            cyc_d = CYC_IDLE;
            cmd_d = OP_ARRAY;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= '0;
         cmd_q <= OP_ARRAY;
         cyc_q <= CYC_IDLE;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cmd_q <= cmd_d;
         cyc_q <= cyc_d;
         cnt_q <= cnt_d;
      end
   end

   always_comb begin
      case (cmd_q)
         OP_ARRAY: rsel = RSEL_ARRAY;
         OP_RD_ID: rsel = RSEL_IDENT;
         OP_QUERY: rsel = RSEL_QUERY;
         default:  rsel = RSEL_STATUS;
      endcase
   end

   assign status = st_q;
   assign cmd    = cmd_q;
   assign cyc    = cyc_q;

endmodule

// File: rtl/nfl_store.sv
module nfl_store #(
   parameter int         BUS_BYTES    = 2,
   parameter int         SECTOR_BYTES = 64,
   parameter int         NUM_SECTORS  = 4,
   parameter bit         BIG_ENDIAN   = 1'b0,
   parameter logic [7:0] INIT_BYTE    = 8'hFF,
   localparam int        DATA_W       = 8 * BUS_BYTES,
   localparam int        TOTAL        = SECTOR_BYTES * NUM_SECTORS,
   localparam int        ADDR_W       = $clog2(TOTAL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              prog_en,
   input  logic              erase_en,
   output logic [DATA_W-1:0] rd_word
);

   localparam int              SEC_W     = $clog2(SECTOR_BYTES);
   localparam logic [ADDR_W-1:0] LANE_MASK = ADDR_W'(BUS_BYTES - 1);

   logic [7:0]        mem [TOTAL];
   logic [ADDR_W-1:0] base;
   logic [DATA_W-1:0] wr_lin, rd_lin;

   assign base = addr & ~LANE_MASK;

   generate
      if (BIG_ENDIAN) begin : g_big
         for (genvar b = 0; b < BUS_BYTES; b++) begin : g_lane
            assign wr_lin[8*b +: 8]                 = wr_data[8*(BUS_BYTES-1-b) +: 8];
            assign rd_word[8*(BUS_BYTES-1-b) +: 8]  = rd_lin[8*b +: 8];
         end
      end else begin : g_little
         assign wr_lin  = wr_data;
         assign rd_word = rd_lin;
      end
   endgenerate

   always_comb begin
      for (int b = 0; b < BUS_BYTES; b++) begin
         rd_lin[8*b +: 8] = mem[base + ADDR_W'(b)];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < TOTAL; i++) mem[i] <= INIT_BYTE;
      end else if (erase_en) begin
         for (int i = 0; i < TOTAL; i++) begin
            if ((ADDR_W'(i) >> SEC_W) == (base >> SEC_W)) mem[i] <= 8'hFF;
         end
      end else if (prog_en) begin
         for (int b = 0; b < BUS_BYTES; b++) begin
            mem[base + ADDR_W'(b)] <= wr_lin[8*b +: 8];
         end
      end
   end

endmodule

// File: rtl/nfl_readmux.sv
module nfl_readmux
   import nfl_pkg::*;
#(
   parameter int         BUS_BYTES    = 2,
   parameter int         SECTOR_BYTES = 64,
   parameter int         NUM_SECTORS  = 4,
   parameter logic [7:0] ID0          = 8'hA5,
   parameter logic [7:0] ID1          = 8'h3C,
   parameter logic [7:0] ID2          = 8'h12,
   parameter logic [7:0] ID3          = 8'h34,
   localparam int        DATA_W       = 8 * BUS_BYTES,
   localparam int        ADDR_W       = $clog2(SECTOR_BYTES * NUM_SECTORS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  rsel_e             rsel,
   input  logic [7:0]        status,
   input  logic [DATA_W-1:0] array_word,
   output logic [DATA_W-1:0] rd_data
);

   localparam int          LANE_W   = $clog2(BUS_BYTES);
   localparam logic [7:0]  BUF_LOG2 = (BUS_BYTES == 1) ? 8'd8 : 8'd11;
   localparam logic [15:0] BLK_M1   = 16'(NUM_SECTORS - 1);
   localparam logic [23:0] SEC_SZ   = 24'(SECTOR_BYTES);

   logic [7:0]        idx;
   logic [7:0]        qbyte;
   logic [DATA_W-1:0] sel_word, rd_q;

   assign idx = 8'(addr) >> LANE_W;

   always_comb begin
      if (idx >= QRY_LEN) begin
         qbyte = 8'h00;
      end else begin
         case (idx)
            8'h10:   qbyte = 8'h51;
            8'h11:   qbyte = 8'h52;
            8'h12:   qbyte = 8'h59;
            8'h13:   qbyte = 8'h01;
            8'h27:   qbyte = 8'(ADDR_W);
            8'h2A:   qbyte = BUF_LOG2;
            8'h2C:   qbyte = 8'h01;
            8'h2D:   qbyte = BLK_M1[7:0];
            8'h2E:   qbyte = BLK_M1[15:8];
            8'h2F:   qbyte = SEC_SZ[15:8];
            8'h30:   qbyte = SEC_SZ[23:16];
            default: qbyte = 8'h00;
         endcase
      end
   end

   always_comb begin
      case (rsel)
         RSEL_ARRAY:  sel_word = array_word;
         RSEL_IDENT: begin
            if (idx == 8'd0)      sel_word = DATA_W'({ID0, ID1});
            else if (idx == 8'd1) sel_word = DATA_W'({ID2, ID3});
            else                  sel_word = '0;
         end
         RSEL_QUERY:  sel_word = DATA_W'(qbyte);
         default:     sel_word = DATA_W'(status);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_en) rd_q <= sel_word;
   end

   assign rd_data = rd_q;

endmodule

// File: rtl/nor_cmd_flash.sv
module nor_cmd_flash
   import nfl_pkg::*;
#(
   parameter int         BUS_BYTES    = 2,
   parameter int         SECTOR_BYTES = 64,
   parameter int         NUM_SECTORS  = 4,
   parameter bit         BIG_ENDIAN   = 1'b0,
   parameter logic [7:0] INIT_BYTE    = 8'hFF,
   parameter logic [7:0] ID0          = 8'hA5,
   parameter logic [7:0] ID1          = 8'h3C,
   parameter logic [7:0] ID2          = 8'h12,
   parameter logic [7:0] ID3          = 8'h34,
   localparam int        DATA_W       = 8 * BUS_BYTES,
   localparam int        ADDR_W       = $clog2(SECTOR_BYTES * NUM_SECTORS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic              ro_mode,
   output logic [DATA_W-1:0] rd_data
);

   generate
      if (BUS_BYTES != 1 && BUS_BYTES != 2 && BUS_BYTES != 4) begin : g_bad_bus
         $error("nor_cmd_flash: BUS_BYTES must be 1, 2 or 4");
      end
      if (NUM_SECTORS < 2 || (NUM_SECTORS & (NUM_SECTORS - 1)) != 0) begin : g_bad_nsec
         $error("nor_cmd_flash: NUM_SECTORS must be a power of two of at least 2");
      end
      if (SECTOR_BYTES < BUS_BYTES || (SECTOR_BYTES & (SECTOR_BYTES - 1)) != 0) begin : g_bad_sec
         $error("nor_cmd_flash: SECTOR_BYTES must be a power of two not below BUS_BYTES");
      end
   endgenerate

   logic              prog_en, erase_en;
   logic [7:0]        seq_status, seq_cmd;
   cyc_e              seq_cyc;
   rsel_e             seq_rsel;
   logic [DATA_W-1:0] array_word;

   nfl_seq #(.DATA_W(DATA_W)) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .ro_mode  (ro_mode),
      .prog_en  (prog_en),
      .erase_en (erase_en),
      .status   (seq_status),
      .cmd      (seq_cmd),
      .cyc      (seq_cyc),
      .rsel     (seq_rsel)
   );

   nfl_store #(
      .BUS_BYTES    (BUS_BYTES),
      .SECTOR_BYTES (SECTOR_BYTES),
      .NUM_SECTORS  (NUM_SECTORS),
      .BIG_ENDIAN   (BIG_ENDIAN),
      .INIT_BYTE    (INIT_BYTE)
   ) store_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (addr),
      .wr_data  (wr_data),
      .prog_en  (prog_en),
      .erase_en (erase_en),
      .rd_word  (array_word)
   );

   nfl_readmux #(
      .BUS_BYTES    (BUS_BYTES),
      .SECTOR_BYTES (SECTOR_BYTES),
      .NUM_SECTORS  (NUM_SECTORS),
      .ID0          (ID0),
      .ID1          (ID1),
      .ID2          (ID2),
      .ID3          (ID3)
   ) rmux_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_en      (rd_en),
      .addr       (addr),
      .rsel       (seq_rsel),
      .status     (seq_status),
      .array_word (array_word),
      .rd_data    (rd_data)
   );

endmodule

// File: rtl/nfl_chk.sv
module nfl_chk
   import nfl_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic              rd_en,
   input logic              ro_mode,
   input logic [DATA_W-1:0] rd_data,
   input logic [7:0]        status,
   input logic [7:0]        cmd,
   input logic [1:0]        cyc
);

   logic idle_wr;
   assign idle_wr = wr_en && (cyc == 2'(CYC_IDLE));

   assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   assert_ro_prog_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ro_mode && cyc == 2'(CYC_ARG) && (cmd == OP_PROG_A || cmd == OP_PROG_B))
      |=> (status[ST_PROG_ER] && status[ST_READY] && cyc == 2'(CYC_IDLE)));

   assert_erase_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_wr && wr_data[7:0] == OP_ERASE) |=> (status[ST_READY] && cyc == 2'(CYC_ARG)));

   assert_clear_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_wr && wr_data[7:0] == OP_CLR_ST) |=> (status == 8'h00 && cmd == OP_ARRAY));

   assert_latch_no_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_wr && (wr_data[7:0] == OP_RD_ST || wr_data[7:0] == OP_RD_ID))
      |=> (cyc == 2'(CYC_IDLE) && cmd == $past(wr_data[7:0])));

   assert_buf_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'(CYC_DATA) || cyc == 2'(CYC_CONFIRM)) |-> (cmd == OP_BUF_WR));

   assert_unknown_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_wr && wr_data[7:0] == 8'h33)
      |=> (cmd == OP_ARRAY && cyc == 2'(CYC_IDLE) && $stable(status)));

endmodule

bind nor_cmd_flash nfl_chk #(.DATA_W(DATA_W)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_data (wr_data),
   .rd_en   (rd_en),
   .ro_mode (ro_mode),
   .rd_data (rd_data),
   .status  (seq_status),
   .cmd     (seq_cmd),
   .cyc     (seq_cyc)
);

// File: tb/nor_cmd_flash_tb_top.sv
module nor_cmd_flash_tb_top;

   localparam int BB  = 2;
   localparam int SB  = 64;
   localparam int NS  = 4;
   localparam int TOT = SB * NS;
   localparam int AW  = $clog2(TOT);
   localparam int DW  = 8 * BB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic          ro_mode = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;

   always #5 clk = ~clk;

   nor_cmd_flash #(.BUS_BYTES(BB), .SECTOR_BYTES(SB), .NUM_SECTORS(NS)) dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (addr),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .ro_mode (ro_mode),
      .rd_data (rd_data)
   );

   int checks = 0;
   int errors = 0;

   // behavioural reference model
   int            m_mem [TOT];
   int            m_mode;   // 0 array, 1 status, 2 ident, 3 query
   int            m_step;   // pending operation kind, 0 none
   int            m_stat;
   int            m_left;
   logic [DW-1:0] exp_rd = '0;
   bit            cmp_on = 1'b0;

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] m_read(input int a);
      int idx = (a & 255) >> 1;
      int b   = a & ~(BB - 1);
      case (m_mode)
         0: return DW'(m_mem[b] | (m_mem[b+1] << 8));
         2: return (idx == 0) ? 16'hA53C : (idx == 1) ? 16'h1234 : 16'h0000;
         3: begin
            if (idx == 'h10) return 16'h51;
            if (idx == 'h11) return 16'h52;
            if (idx == 'h12) return 16'h59;
            if (idx == 'h2A) return 16'd11;
            return 16'h0;
         end
         default: return DW'(m_stat);
      endcase
   endfunction

   task automatic m_to_array();
      m_mode = 0;
      m_step = 0;
   endtask

   task automatic m_write(input int a, input int d);
      int c = d & 255;
      int b = a & ~(BB - 1);
      // m_step: 0 idle, 1 program armed, 2 erase confirm, 3 lock arg,
      // 4 query, 5 buffer count, 6 buffer data, 7 buffer confirm
      case (m_step)
         0: begin
            if (c == 'h10 || c == 'h40) begin m_step = 1; m_mode = 1; end
            else if (c == 'h20) begin
               if (ro_mode) m_stat |= 'h20;
               else for (int i = 0; i < SB; i++) m_mem[(a / SB) * SB + i] = 'hFF;
               m_stat |= 'h80; m_step = 2; m_mode = 1;
            end
            else if (c == 'h60) begin m_step = 3; m_mode = 1; end
            else if (c == 'h98) begin m_step = 4; m_mode = 3; end
            else if (c == 'hE8) begin m_stat |= 'h80; m_step = 5; m_mode = 1; end
            else if (c == 'h70) m_mode = 1;
            else if (c == 'h90) m_mode = 2;
            else begin
               if (c == 'h50) m_stat = 0;
               m_to_array();
            end
         end
         1: begin
            if (ro_mode) m_stat |= 'h10;
            else begin m_mem[b] = d & 255; m_mem[b+1] = (d >> 8) & 255; end
            m_stat |= 'h80; m_step = 0;
         end
         2: if (c == 'hD0) begin m_stat |= 'h80; m_step = 0; end else m_to_array();
         3: if (c == 'hD0 || c == 'h01) begin m_stat |= 'h80; m_step = 0; end else m_to_array();
         4: if (c == 'hFF) m_to_array();
         5: begin m_left = d; m_step = 6; end
         6: begin
            if (ro_mode) m_stat |= 'h10;
            else begin m_mem[b] = d & 255; m_mem[b+1] = (d >> 8) & 255; end
            m_stat |= 'h80;
            if (m_left == 0) m_step = 7; else m_left--;
         end
         default: if (c == 'hD0) begin m_stat |= 'h80; m_step = 0; end else m_to_array();
      endcase
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      m_write(a, d);
      addr    = AW'(a);
      wr_data = DW'(d);
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic rdchk(input int a, input logic [DW-1:0] exp, input string req);
      logic [DW-1:0] e;
      @(negedge clk);
      e     = m_read(a);
      addr  = AW'(a);
      rd_en = 1'b1;
      @(posedge clk);
      exp_rd = e;
      @(negedge clk);
      rd_en = 1'b0;
      chk(req, rd_data, exp);
   endtask

   // cycle-by-cycle comparison against the reference model
   always @(negedge clk) begin
      if (cmp_on) chk("R2 model compare", rd_data, exp_rd);
   end

   initial begin
      #(200000 * 10);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < TOT; i++) m_mem[i] = 'hFF;
      m_mode = 0; m_step = 0; m_stat = 0; m_left = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rd_data after reset", rd_data, '0);
      cmp_on = 1'b1;

      // R1 reset state
      wr(0, 'h70);
      rdchk(0, 16'h0000, "R1 status after reset");
      wr(0, 'hFF);
      rdchk(0, 16'hFFFF, "R1 preload");

      // R3 program, R2 lane ordering
      wr('h10, 'h40);
      wr('h10, 'h1234);
      rdchk(0, 16'h0080, "R3 status after program");
      wr(0, 'hFF);
      rdchk('h10, 16'h1234, "R3 programmed word");
      rdchk('h11, 16'h1234, "R2 low lane bit ignored");
      wr('h44, 'h10);
      wr('h44, 'h5566);
      wr(0, 'hFF);
      rdchk('h44, 16'h5566, "R3 alternate program op");

      // R4 read-only program
      @(negedge clk) ro_mode = 1'b1;
      wr('h10, 'h40);
      wr('h10, 'h0000);
      rdchk(0, 16'h0090, "R4 program error bit");
      wr(0, 'hFF);
      rdchk('h10, 16'h1234, "R4 array unchanged");

      // R6 clear status
      wr(0, 'h50);
      rdchk('h10, 16'h1234, "R6 back to array");
      wr(0, 'h70);
      rdchk(0, 16'h0000, "R6 status cleared");

      // R5 read-only erase
      wr('h10, 'h20);
      rdchk(0, 16'h00A0, "R5 erase error bit");
      wr('h10, 'hD0);
      rdchk(0, 16'h00A0, "R5 status after confirm");
      wr(0, 'hFF);
      rdchk('h10, 16'h1234, "R5 read-only erase kept data");
      wr(0, 'h50);
      @(negedge clk) ro_mode = 1'b0;

      // R5 erase of sector 0 only
      wr('h06, 'h20);
      wr('h06, 'hD0);
      rdchk(0, 16'h0080, "R5 ready after erase");
      wr(0, 'hFF);
      rdchk('h10, 16'hFFFF, "R5 sector erased");
      rdchk('h44, 16'h5566, "R5 other sector kept");

      // R7 identifier and status reads
      wr(0, 'h90);
      rdchk(0, 16'hA53C, "R7 ident word 0");
      rdchk(2, 16'h1234, "R7 ident word 1");
      rdchk(4, 16'h0000, "R7 ident other index");
      wr(0, 'h70);
      rdchk(0, 16'h0080, "R7 status read");

      // R8 query mode
      wr(0, 'h98);
      rdchk('h20, 16'h0051, "R8 query Q");
      rdchk('h22, 16'h0052, "R8 query R");
      rdchk('h24, 16'h0059, "R8 query Y");
      rdchk('h54, 16'h000B, "R8 buffer exponent");
      rdchk('hA4, 16'h0000, "R8 past table end");
      wr(0, 'h00);
      rdchk('h20, 16'h0051, "R8 query kept");
      wr(0, 'hFF);
      rdchk('h44, 16'h5566, "R8 leave query");

      // R9 lock and unlock
      wr(0, 'h50);
      wr('h40, 'h60);
      wr('h40, 'hD0);
      rdchk(0, 16'h0080, "R9 lock confirm");
      wr(0, 'h50);
      wr('h40, 'h60);
      wr('h40, 'h01);
      rdchk(0, 16'h0080, "R9 unlock alt");
      wr('h40, 'h60);
      wr('h40, 'h55);
      rdchk('h44, 16'h5566, "R9 bad second value");

      // R10 buffered write of four words
      wr(0, 'h50);
      wr('h80, 'hE8);
      rdchk('h80, 16'h0080, "R10 ready after start");
      wr('h80, 3);
      wr('h80, 'h1111);
      wr('h82, 'h2222);
      wr('h84, 'h3333);
      rdchk(0, 16'h0080, "R10 ready mid-buffer");
      wr('h86, 'h4444);
      wr('h80, 'hD0);
      rdchk(0, 16'h0080, "R10 ready after confirm");
      wr(0, 'hFF);
      rdchk('h80, 16'h1111, "R10 word 0");
      rdchk('h82, 16'h2222, "R10 word 1");
      rdchk('h84, 16'h3333, "R10 word 2");
      rdchk('h86, 16'h4444, "R10 word 3");
      rdchk('h88, 16'hFFFF, "R10 word after buffer");

      // R11 unsupported sequences
      wr('hC0, 'h20);
      wr('hC0, 'h77);
      rdchk('hC0, 16'hFFFF, "R11 bad erase confirm");
      wr(0, 'h70);
      rdchk(0, 16'h0080, "R11 status kept");
      wr(0, 'h33);
      rdchk('h44, 16'h5566, "R11 unknown op");
      wr(0, 'h70);
      rdchk(0, 16'h0080, "R11 status kept after unknown");

      // R12 return-to-array ops
      wr(0, 'hF0);
      rdchk('h44, 16'h5566, "R12 alt reset op");
      wr(0, 'h90);
      wr(0, 'h00);
      rdchk('h44, 16'h5566, "R12 zero op");
      wr(0, 'h70);
      rdchk(0, 16'h0080, "R12 status untouched");

      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule